// File: doc/BRIEF.md
# Instruction Count Debug Trigger

This block is one debug trigger slot configured as an instruction counter. Software writes a remaining count and a set of privilege-mode enables into the trigger's primary control word. After that, each retired instruction decrements the count if the hart was running in a mode that the trigger enables. When the count steps from one to zero, the block raises a one-cycle request that the core turns into a breakpoint exception. A count of zero leaves the trigger idle until software writes a new count.

The hart supplies a retire strobe, its current privilege level and a flag that says whether it runs virtualized. When the hart is virtualized, only the two virtual-mode enables decide whether an instruction counts. Otherwise the user, supervisor and machine enables decide. The control word that reads back holds the live remaining count, the mode enables that were kept, and a constant type code. Every other bit reads as zero. Writes to the two secondary data registers are ignored for this trigger kind.

Top module: `icnt_trigger`

## Requirements
- R1: After reset, the count is 0, all mode enables are clear, `trig_req` is low and `ctrl_rdata` equals 0x3000_0000, which is type code 3 in bits [31:28] and nothing else.
- R2: A write with `csr_wr_sel`=1 loads the count from bits [23:10] and the enables from M=bit 9, S=bit 7, U=bit 6, VS=bit 25 and VU=bit 26. On readback every other bit is zero, and bits [31:28] read 3 whatever value was written there.
- R3: When `virt`=0, a retirement at privilege 0 (user), 1 (supervisor) or 3 (machine) decrements the count only if the U, S or M enable for that level is set. A retirement at any other privilege, including the reserved value 2, leaves the count unchanged.
- R4: When `virt`=1, a retirement at privilege 0 counts only if VU is set and one at privilege 1 counts only if VS is set. The U, S and M enables are not consulted, and privilege 3 never counts.
- R5: A counted retirement that takes the count from 1 to 0 drives `trig_req` high for exactly one cycle. That cycle follows the retirement edge and is the same cycle in which the count first reads 0.
- R6: While the count is 0, retirements neither change the count nor raise `trig_req`.
- R7: Writes with `csr_wr_sel`=2 or 3 change neither the count nor the enables.
- R8: One cycle after each counted retirement, `live_count` and bits [23:10] of `ctrl_rdata` both show the new remaining count.
- R9: When a `csr_wr_sel`=1 write and a counted retirement fall on the same cycle, the written count is stored without a decrement and no request is raised.
- R10: The largest count, 16383, loads intact and decrements to 16382.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_sel | input | 2 | Write target: 1 control word, 2 and 3 secondary data |
| csr_wr_data | input | XLEN | Write data |
| retire_vld | input | 1 | One instruction retired this cycle |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt | input | 1 | Hart is running virtualized |
| ctrl_rdata | output | XLEN | Control word readback with the live count |
| live_count | output | CNT_W | Remaining count |
| trig_req | output | 1 | One-cycle breakpoint request |

## Verification
The bench targets the places where counting is easy to get wrong. The first is privilege qualification in both the plain and the virtualized case. A design that checks the wrong enable set would count while the hart runs in a disabled mode, or miss instructions in an enabled one. The second is the step from one to zero, where an unregistered or sticky request would be either missed or seen over two cycles. The bench also retires instructions while the count is zero, which exposes an underflow that wraps to 16383 and would fire again. It writes a new count in the same cycle as a retirement, which exposes the wrong priority. Finally it writes all ones into the control word and the secondary registers, which exposes bits that should have been dropped and writes that should have been ignored.

// File: rtl/icnt_pkg.sv
package icnt_pkg;

    // Type code reported in the control word's top nibble.
    localparam int unsigned TYPE_LSB   = 28;
    localparam int unsigned TYPE_W     = 4;
    localparam logic [3:0]  TYPE_ICNT  = 4'd3;

    // Mode enable bit positions inside the control word.
    localparam int unsigned BIT_U  = 6;
    localparam int unsigned BIT_S  = 7;
    localparam int unsigned BIT_M  = 9;
    localparam int unsigned BIT_VS = 25;
    localparam int unsigned BIT_VU = 26;

    // Write target selector values.
    localparam logic [1:0] SEL_CTRL = 2'd1;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef struct packed {
        logic vu;
        logic vs;
        logic m;
        logic s;
        logic u;
    } mode_en_t;

    // Decide whether a retirement in the given mode is counted.
    function automatic logic mode_counts(mode_en_t en, priv_e lvl, logic is_virt);
        logic hit;
        hit = 1'b0;
        if (is_virt) begin
            case (lvl)
                PRIV_USER:  hit = en.vu;
                PRIV_SUPER: hit = en.vs;
                default:    hit = 1'b0;
            endcase
        end else begin
            case (lvl)
                PRIV_USER:  hit = en.u;
                PRIV_SUPER: hit = en.s;
                PRIV_MACH:  hit = en.m;
                default:    hit = 1'b0;
            endcase
        end
        return hit;
    endfunction

endpackage

// File: rtl/icnt_priv_filter.sv
module icnt_priv_filter
    import icnt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mode_en_t modes,
    input  priv_e    lvl,
    input  logic     is_virt,
    output logic     qual
);

    always_comb begin
        qual = mode_counts(modes, lvl, is_virt);
    end

    // R4: machine level never counts while virtualized
    p_virt_mach_blocked_r4: assert property (@(posedge clk) disable iff (rst)
        (is_virt && lvl == PRIV_MACH) |-> !qual);

    // R3: the reserved level never counts
    p_rsvd_blocked_r3: assert property (@(posedge clk) disable iff (rst)
        (lvl == PRIV_RSVD) |-> !qual);

endmodule

// File: rtl/icnt_counter.sv
module icnt_counter #(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             fire
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic armed;
    assign armed = (count != CNT_ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= CNT_ZERO;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (load) begin
                count <= load_val;
            end else if (step && armed) begin
                count <= count - CNT_ONE;
                fire  <= (count == CNT_ONE);
            end
        end
    end

    // R3: without a qualified step or a load the count holds
    p_hold_unqualified_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(count));

    // R5: stepping from one raises the request next cycle
    p_fire_on_last_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && step && count == CNT_ONE) |=> (fire && count == CNT_ZERO));

    // R5: request never lasts two cycles
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    // R6: an empty count stays empty and silent
    p_zero_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && count == CNT_ZERO) |=> (count == CNT_ZERO && !fire));

    // R9: a load wins over a simultaneous step
    p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val) && !fire));

endmodule

// File: rtl/icnt_ctrl_reg.sv
module icnt_ctrl_reg
    import icnt_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CNT_W   = 14,
    parameter int unsigned CNT_LSB = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [CNT_W-1:0] live_count,
    output mode_en_t         modes,
    output logic [CNT_W-1:0] load_val,
    output logic [XLEN-1:0]  rdata
);

    localparam int unsigned CNT_MSB = CNT_LSB + CNT_W - 1;

    mode_en_t wr_modes;

    always_comb begin
        wr_modes.u  = wr_data[BIT_U];
        wr_modes.s  = wr_data[BIT_S];
        wr_modes.m  = wr_data[BIT_M];
        wr_modes.vs = wr_data[BIT_VS];
        wr_modes.vu = wr_data[BIT_VU];
    end

    assign load_val = wr_data[CNT_MSB:CNT_LSB];

    always_ff @(posedge clk) begin
        if (rst) begin
            modes <= '0;
        end else if (wr_en) begin
            modes <= wr_modes;
        end
    end

    always_comb begin
        rdata                            = '0;
        rdata[TYPE_LSB +: TYPE_W]        = TYPE_ICNT;
        rdata[CNT_MSB:CNT_LSB]           = live_count;
        rdata[BIT_U]                     = modes.u;
        rdata[BIT_S]                     = modes.s;
        rdata[BIT_M]                     = modes.m;
        rdata[BIT_VS]                    = modes.vs;
        rdata[BIT_VU]                    = modes.vu;
    end

    // R7: enables change only on a control-word write
    p_modes_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(modes));

endmodule

// File: rtl/icnt_trigger.sv
module icnt_trigger
    import icnt_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CNT_W   = 14,
    parameter int unsigned CNT_LSB = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_wr_en,
    input  logic [1:0]       csr_wr_sel,
    input  logic [XLEN-1:0]  csr_wr_data,
    input  logic             retire_vld,
    input  logic [1:0]       priv,
    input  logic             virt,
    output logic [XLEN-1:0]  ctrl_rdata,
    output logic [CNT_W-1:0] live_count,
    output logic             trig_req
);

    logic             ctrl_wr;
    mode_en_t         modes;
    logic [CNT_W-1:0] load_val;
    logic             qual;
    logic             step;

    assign ctrl_wr = csr_wr_en && (csr_wr_sel == SEL_CTRL);
    assign step    = retire_vld && qual;

    icnt_ctrl_reg #(
        .XLEN    (XLEN),
        .CNT_W   (CNT_W),
        .CNT_LSB (CNT_LSB)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (ctrl_wr),
        .wr_data    (csr_wr_data),
        .live_count (live_count),
        .modes      (modes),
        .load_val   (load_val),
        .rdata      (ctrl_rdata)
    );

    icnt_priv_filter u_filter (
        .clk     (clk),
        .rst     (rst),
        .modes   (modes),
        .lvl     (priv_e'(priv)),
        .is_virt (virt),
        .qual    (qual)
    );

    icnt_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (ctrl_wr),
        .load_val (load_val),
        .step     (step),
        .count    (live_count),
        .fire     (trig_req)
    );

    // R7: secondary-register writes leave the count alone
    p_aux_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (csr_wr_en && csr_wr_sel != SEL_CTRL && !retire_vld) |=> $stable(live_count));

endmodule

// File: tb/tb_icnt_trigger.sv
module tb_icnt_trigger;

    localparam int XLEN = 32;
    localparam int CNT_W = 14;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             csr_wr_en = 1'b0;
    logic [1:0]       csr_wr_sel = 2'd0;
    logic [XLEN-1:0]  csr_wr_data = '0;
    logic             retire_vld = 1'b0;
    logic [1:0]       priv = 2'd3;
    logic             virt = 1'b0;
    logic [XLEN-1:0]  ctrl_rdata;
    logic [CNT_W-1:0] live_count;
    logic             trig_req;

    int n_checks = 0;
    int n_fail   = 0;
    int fire_cnt = 0;

    always #2 clk = ~clk;

    icnt_trigger dut (
        .clk         (clk),
        .rst         (rst),
        .csr_wr_en   (csr_wr_en),
        .csr_wr_sel  (csr_wr_sel),
        .csr_wr_data (csr_wr_data),
        .retire_vld  (retire_vld),
        .priv        (priv),
        .virt        (virt),
        .ctrl_rdata  (ctrl_rdata),
        .live_count  (live_count),
        .trig_req    (trig_req)
    );

    always @(negedge clk) begin
        if (!rst && trig_req) fire_cnt++;
    end

    function automatic logic [31:0] mk(int cnt, bit m, bit s, bit u, bit vs, bit vu);
        logic [31:0] w;
        w = 32'h3000_0000;
        w[23:10] = cnt[13:0];
        w[9] = m; w[7] = s; w[6] = u; w[25] = vs; w[26] = vu;
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] data);
        csr_wr_en = 1'b1; csr_wr_sel = sel; csr_wr_data = data;
        tick();
        csr_wr_en = 1'b0;
    endtask

    task automatic retire(logic [1:0] p, logic v, int n);
        for (int i = 0; i < n; i++) begin
            retire_vld = 1'b1; priv = p; virt = v;
            tick();
        end
        retire_vld = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rdata", ctrl_rdata, 32'h3000_0000);
        check("R1 count", 32'(live_count), 32'd0);
        check("R1 trig", 32'(trig_req), 32'd0);
    endtask

    task automatic t_fields();
        wr(2'd1, 32'hFFFF_FFFF);
        check("R2 all-ones readback", ctrl_rdata, mk(16383, 1, 1, 1, 1, 1));
        wr(2'd1, 32'h0000_0000 | (32'd5 << 10) | (32'd1 << 9));
        check("R2 type forced", ctrl_rdata, mk(5, 1, 0, 0, 0, 0));
    endtask

    task automatic t_nonvirt();
        wr(2'd1, mk(10, 1, 0, 1, 0, 0));
        retire(2'd3, 1'b0, 2);
        check("R3 machine counts", 32'(live_count), 32'd8);
        retire(2'd1, 1'b0, 3);
        check("R3 supervisor disabled", 32'(live_count), 32'd8);
        retire(2'd0, 1'b0, 1);
        check("R3 user counts", 32'(live_count), 32'd7);
        retire(2'd2, 1'b0, 1);
        check("R3 reserved level", 32'(live_count), 32'd7);
    endtask

    task automatic t_virt();
        wr(2'd1, mk(10, 1, 1, 1, 0, 1));
        retire(2'd1, 1'b1, 2);
        check("R4 VS clear ignores S", 32'(live_count), 32'd10);
        retire(2'd0, 1'b1, 3);
        check("R4 VU counts", 32'(live_count), 32'd7);
        retire(2'd3, 1'b1, 1);
        check("R4 machine under virt", 32'(live_count), 32'd7);
        wr(2'd1, mk(10, 0, 0, 0, 1, 0));
        retire(2'd1, 1'b1, 1);
        check("R4 VS counts", 32'(live_count), 32'd9);
        retire(2'd1, 1'b0, 1);
        check("R4 S clear outside virt", 32'(live_count), 32'd9);
    endtask

    task automatic t_fire();
        int f0;
        f0 = fire_cnt;
        wr(2'd1, mk(3, 0, 0, 1, 0, 0));
        retire(2'd0, 1'b0, 1);
        check("R8 rdata count", 32'(ctrl_rdata[23:10]), 32'd2);
        check("R8 live count", 32'(live_count), 32'd2);
        retire(2'd0, 1'b0, 1);
        check("R5 no early fire", 32'(trig_req), 32'd0);
        retire(2'd0, 1'b0, 1);
        check("R5 fire high", 32'(trig_req), 32'd1);
        check("R5 count zero", 32'(live_count), 32'd0);
        tick();
        check("R5 fire drops", 32'(trig_req), 32'd0);
        check("R5 one pulse", 32'(fire_cnt - f0), 32'd1);
    endtask

    task automatic t_zero();
        int f0;
        f0 = fire_cnt;
        retire(2'd0, 1'b0, 4);
        check("R6 count stays zero", 32'(live_count), 32'd0);
        tick();
        check("R6 no fire", 32'(fire_cnt - f0), 32'd0);
    endtask

    task automatic t_aux();
        wr(2'd1, mk(20, 1, 0, 0, 0, 0));
        wr(2'd2, 32'hFFFF_FFFF);
        check("R7 tdata2 write ignored", ctrl_rdata, mk(20, 1, 0, 0, 0, 0));
        wr(2'd3, 32'h0000_0000);
        check("R7 tdata3 write ignored", ctrl_rdata, mk(20, 1, 0, 0, 0, 0));
    endtask

    task automatic t_priority();
        int f0;
        wr(2'd1, mk(5, 1, 0, 0, 0, 0));
        csr_wr_en = 1'b1; csr_wr_sel = 2'd1; csr_wr_data = mk(1, 1, 0, 0, 0, 0);
        retire_vld = 1'b1; priv = 2'd3; virt = 1'b0;
        tick();
        check("R9 write wins", 32'(live_count), 32'd1);
        f0 = fire_cnt;
        tick();
        check("R9 no decrement from 1", 32'(live_count), 32'd1);
        csr_wr_en = 1'b0; retire_vld = 1'b0;
        tick();
        check("R9 no fire", 32'(fire_cnt - f0), 32'd0);
        retire(2'd3, 1'b0, 1);
        check("R9 later fire", 32'(trig_req), 32'd1);
        tick();
    endtask

    task automatic t_max();
        wr(2'd1, mk(16383, 0, 1, 0, 0, 0));
        check("R10 max load", 32'(live_count), 32'd16383);
        retire(2'd1, 1'b0, 1);
        check("R10 max decrement", 32'(live_count), 32'd16382);
    endtask

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_fields();
        t_nonvirt();
        t_virt();
        t_fire();
        t_zero();
        t_aux();
        t_priority();
        t_max();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule